// File: doc/BRIEF.md
# Hard Trap Conflict Detector

This block supervises a small, fixed set of hard trap sources in a processor core. Each source moves through four phases: idle, pending, acknowledged and in service. The highest-priority source that is not idle is the selected trap. While the selected trap waits for its acknowledge, the block holds a stall output high, so no instruction can execute until the trap is taken. Once a trap is acknowledged, the block raises a trap-level indication for as long as any trap is executing.

A higher-priority trap that arrives while a lower one is active takes over and becomes the selected trap. A lower-priority trap is different. If it is raised while any higher-priority source is in any phase other than idle, that is a fatal conflict. On a conflict the block returns every source to idle and sends a one-cycle reset request to the device. It also sets a sticky cause flag. The conflict reset does not clear that flag; only a software clear strobe or a power-on reset does.

Vector fetch and the device reset sequence itself are handled outside this block.

Top module: `hard_trap_guard`

## Requirements
- R1: After power-on reset (`por_n` low), all sources are idle. `trap_valid`, `trap_id`, `stall`, `ipl3`, `rst_req` and `conflict_flag` are all 0.
- R2: A request on an idle source makes that source pending on the next clock edge. From then on `trap_valid` and `stall` are 1 and `trap_id` shows the selected source.
- R3: Source index 0 has the highest priority and index 3 the lowest. The indices map as: 0 oscillator failure, 1 address error, 2 stack error, 3 math error. `trap_id` is the lowest non-idle index. A request from a higher-priority source while a lower one is active preempts it without a conflict. The lower source resumes once the higher one completes.
- R4: `trap_ack` moves the selected source from pending to acknowledged, and `stall` falls after that edge. `trap_ack` has no effect when the selected source is not pending.
- R5: An acknowledged source enters service on the next edge without any other input. `svc_done` returns the selected source to idle if it is acknowledged or in service. `svc_done` has no effect on a pending source.
- R6: `ipl3` is 1 exactly when at least one source is acknowledged or in service. A source that is only pending does not raise it.
- R7: A conflict is a request on an idle source while any higher-priority source is not idle, whether that higher source is pending, acknowledged or in service. After a conflict edge, `rst_req` is 1 for exactly one cycle and all sources are idle.
- R8: A conflict sets `conflict_flag`. The flag holds through the conflict reset and clears only on `stat_clr` or power-on reset. If a conflict and `stat_clr` occur in the same cycle, the set takes precedence.
- R9: Requests that reach several idle sources in the same cycle while none is active are not a conflict. All of them become pending and they are served in priority order.
- R10: A request on a source that is already not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| trap_req | input | N_SRC | Trap request per source, index 0 highest priority |
| trap_ack | input | 1 | Acknowledge strobe for the selected trap |
| svc_done | input | 1 | Service-complete strobe for the selected trap |
| stat_clr | input | 1 | Software write that clears the conflict flag |
| trap_valid | output | 1 | Some source is not idle |
| trap_id | output | ID_W | Index of the selected trap |
| stall | output | 1 | Execution held until the selected trap is acknowledged |
| ipl3 | output | 1 | A trap is executing (acknowledged or in service) |
| rst_req | output | 1 | One-cycle device reset request on a conflict |
| conflict_flag | output | 1 | Sticky record that a conflict reset occurred |

## Verification
The hardest conditions to reach are conflicts against a higher source sitting in each of its three busy phases, and in particular a conflict that coincides with a software clear. The stimulus table first walks a stack trap into service. It then preempts that trap with an oscillator trap and unwinds it. After that it raises a lower source on top of an acknowledged-plus-preempting pair, on top of an acknowledged trap while `stat_clr` is also high, and on top of a merely pending trap. A final power-on reset while the flag is set shows that only that reset path clears it without software.

// File: rtl/hard_trap_guard.sv
module hard_trap_guard #(
  parameter int N_SRC = 4,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [N_SRC-1:0] trap_req,
  input  logic             trap_ack,
  input  logic             svc_done,
  input  logic             stat_clr,
  output logic             trap_valid,
  output logic [ID_W-1:0]  trap_id,
  output logic             stall,
  output logic             ipl3,
  output logic             rst_req,
  output logic             conflict_flag
);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_ACKD, S_SVC} phase_t;

  phase_t            ph_q [N_SRC];
  phase_t            ph_d [N_SRC];
  logic [N_SRC-1:0]  busy, above_busy, fresh;
  logic [ID_W-1:0]   sel;
  logic              conflict;
  logic              rst_q, flag_q;

  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      busy[i]       = (ph_q[i] != S_IDLE);
      above_busy[i] = run;
      fresh[i]      = trap_req[i] && (ph_q[i] == S_IDLE);
      run           = run | busy[i];
    end
  end

  always_comb begin
    sel = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (busy[i]) sel = ID_W'(i);
  end

  assign conflict = |(fresh & above_busy);

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      ph_d[i] = ph_q[i];
      if (conflict) ph_d[i] = S_IDLE;
      else begin
        case (ph_q[i])
          S_IDLE: if (trap_req[i]) ph_d[i] = S_PEND;
          S_PEND: if (trap_ack && sel == ID_W'(i)) ph_d[i] = S_ACKD;
          S_ACKD: ph_d[i] = (svc_done && sel == ID_W'(i)) ? S_IDLE : S_SVC;
          S_SVC:  if (svc_done && sel == ID_W'(i)) ph_d[i] = S_IDLE;
          default: ph_d[i] = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < N_SRC; i++) ph_q[i] <= S_IDLE;
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      for (int i = 0; i < N_SRC; i++) ph_q[i] <= ph_d[i];
      rst_q <= conflict;
      if (conflict)      flag_q <= 1'b1;
      else if (stat_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ipl3 = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (ph_q[i] == S_ACKD || ph_q[i] == S_SVC) ipl3 = 1'b1;
  end

  assign trap_valid    = |busy;
  assign trap_id       = sel;
  assign stall         = (ph_q[sel] == S_PEND);
  assign rst_req       = rst_q;
  assign conflict_flag = flag_q;

  a_r7_reset_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);
  a_r7_reset_clears_all: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> !trap_valid);
  a_r8_flag_with_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> conflict_flag);
  a_r8_flag_only_sw_clear: assert property (@(posedge clk) disable iff (!por_n)
    $fell(conflict_flag) |-> $past(stat_clr));
  a_r4_ack_drops_stall: assert property (@(posedge clk) disable iff (!por_n)
    (stall && trap_ack && trap_req == '0) |=> !stall);
  a_r6_ipl3_needs_trap: assert property (@(posedge clk) disable iff (!por_n)
    ipl3 |-> trap_valid);
  a_r2_stall_needs_trap: assert property (@(posedge clk) disable iff (!por_n)
    stall |-> trap_valid);

endmodule

// File: tb/test_hard_trap_guard.sv
`timescale 1ns/1ps
module test_hard_trap_guard;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [3:0] trap_req = '0;
  logic       trap_ack = 1'b0, svc_done = 1'b0, stat_clr = 1'b0;
  logic       trap_valid, stall, ipl3, rst_req, conflict_flag;
  logic [1:0] trap_id;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  hard_trap_guard i_hard_trap_guard (
    .clk(clk), .por_n(por_n), .trap_req(trap_req), .trap_ack(trap_ack),
    .svc_done(svc_done), .stat_clr(stat_clr), .trap_valid(trap_valid),
    .trap_id(trap_id), .stall(stall), .ipl3(ipl3), .rst_req(rst_req),
    .conflict_flag(conflict_flag));

  // {req[3:0], ack, done, clr, valid, id[1:0], stall, ipl3, rst, flag}
  localparam int NV = 26;
  localparam logic [13:0] VEC [NV] = '{
    14'b0100_000_1_10_1_0_0_0, // R2 stack pending
    14'b0000_100_1_10_0_1_0_0, // R4 ack
    14'b0000_000_1_10_0_1_0_0, // R5 auto service
    14'b0001_000_1_00_1_1_0_0, // R3 osc preempts
    14'b0000_100_1_00_0_1_0_0, // R4
    14'b0000_010_1_10_0_1_0_0, // R3 R5 resume stack
    14'b0000_010_0_00_0_0_0_0, // R5 idle
    14'b1010_000_1_01_1_0_0_0, // R9 simultaneous
    14'b0000_010_1_01_1_0_0_0, // R5 done ignored on pending
    14'b0000_100_1_01_0_1_0_0, // R6
    14'b0000_010_1_11_1_0_0_0, // R9 math next
    14'b0000_100_1_11_0_1_0_0, // R4
    14'b0010_000_1_01_1_1_0_0, // R3 addr preempts
    14'b0100_000_0_00_0_0_1_1, // R7 conflict
    14'b0000_000_0_00_0_0_0_1, // R7 one cycle, R8 sticky
    14'b0000_100_0_00_0_0_0_1, // R4 ack ignored
    14'b0001_000_1_00_1_0_0_1, // R2
    14'b0001_000_1_00_1_0_0_1, // R10 repeat ignored
    14'b0000_001_1_00_1_0_0_0, // R8 clear
    14'b0000_100_1_00_0_1_0_0, // R6
    14'b1000_001_0_00_0_0_1_1, // R8 set wins over clear
    14'b0000_000_0_00_0_0_0_1, // R7
    14'b0000_001_0_00_0_0_0_0, // R8 clear
    14'b0100_000_1_10_1_0_0_0, // R2
    14'b1000_000_0_00_0_0_1_1, // R7 conflict on pending
    14'b0000_000_0_00_0_0_0_1  // R8
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [6:0] e);
    chk({tag, " valid"}, trap_valid, e[6]);
    chk({tag, " id"}, trap_id, e[5:4]);
    chk({tag, " stall"}, stall, e[3]);
    chk({tag, " ipl3"}, ipl3, e[2]);
    chk({tag, " rst_req"}, rst_req, e[1]);
    chk({tag, " flag"}, conflict_flag, e[0]);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 7'b0);
    por_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 7'b0);
    for (int k = 0; k < NV; k++) begin
      trap_req = VEC[k][13:10];
      trap_ack = VEC[k][9];
      svc_done = VEC[k][8];
      stat_clr = VEC[k][7];
      @(negedge clk);
      chk_all($sformatf("R%0s step %0d", "x", k), VEC[k][6:0]);
    end
    trap_req = '0; trap_ack = 0; svc_done = 0; stat_clr = 0;
    @(negedge clk);
    chk("R8 flag still set", conflict_flag, 1);
    por_n = 1'b0;
    #1;
    chk("R8 por clears flag", conflict_flag, 0);
    chk("R1 por clears valid", trap_valid, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule